// File: doc/BRIEF.md
# Guarded Scaled-Index Word Load Unit

This block carries out one predicated 32-bit load for each accepted issue. The issue side supplies a base value, an index value, a guard bit, a destination tag and a byte-order mode bit. The unit forms the effective address as base plus four times the index, wrapping modulo 2^32. It presents the word address to a synchronous data memory read port. It then reorders the four returned bytes according to the byte order that applies to that load. Three cycles after issue it hands a register write-back to the register file.

Alongside each write-back the unit flags two things: whether the address fell in the memory-mapped I/O window, and whether a cache-status update is due. A load whose guard bit is clear behaves as a bubble. It makes no memory read, produces no write-back and raises no strobe.

The issue side is a valid/ready stream, and the unit applies no back-pressure. `iss_ready` is low only while reset is held, and an issue counts only in a cycle where both `iss_valid` and `iss_ready` are high. A new load may be accepted in every cycle. The write-back side has no ready, because the register file port accepts every cycle. The memory port is a plain read strobe with a fixed one-cycle return.

Top module: `ldx_word_unit`

## Requirements
- R1: In an issue cycle where the guard bit is 1, `mem_rd_en` is 1 and `mem_waddr` equals bits [31:2] of (`iss_base` + 4 × `iss_index`) mod 2^32. An index of 0xFFFFFFFE therefore lowers the address by eight.
- R2: Memory byte offset j of a word is carried on `mem_rdata[8j+7:8j]`. With `iss_little` = 0 (big-endian), result byte k (bits [8k+7:8k]) takes memory byte offset 3−k. For example, bytes 0x84, 0x33, 0x22, 0x11 at rising offsets give 0x84332211.
- R3: With `iss_little` = 1, result byte k takes memory byte offset k. The word passes through unchanged.
- R4: A guarded load issued in cycle t gives `wb_valid` = 1 with its tag and data in cycle t+3 and in no other cycle. Loads may issue on consecutive cycles and write back in issue order.
- R5: When the guard bit is 0, `mem_rd_en` stays 0 in the issue cycle. Three cycles later `wb_valid`, `wb_mmio` and `wb_cache_upd` all stay 0.
- R6: An effective address with nonzero bits [1:0] raises no fault. A guarded load to such an address still writes back with its tag (data is don't-care), and `mem_waddr` is the truncated word address.
- R7: When the effective address lies in [MMIO_BASE, MMIO_LIMIT], the byte order is the little-endian order of R3 whatever `iss_little` says, and `wb_mmio` = 1 with the write-back.
- R8: `wb_cache_upd` = 1 with a write-back exactly when the address lies in [CACHE_BASE, CACHE_LIMIT] and outside the I/O window. `wb_mmio` and `wb_cache_upd` are never 1 together, and neither is 1 without `wb_valid`.
- R9: The byte-order mode, guard and tag are captured at issue. Changing `iss_little` on the following cycles does not alter a load already in flight.
- R10: A synchronous active-high `rst` clears every in-flight load. No write-back appears in the cycles after reset for any load that issued before it.
- R11: `iss_ready` is 0 while `rst` is 1 and 1 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Issue accepted when high |
| iss_base | input | 32 | Base operand |
| iss_index | input | 32 | Index operand, scaled by four |
| iss_guard | input | 1 | Least significant bit of the guard operand |
| iss_tag | input | TAG_W | Destination register tag |
| iss_little | input | 1 | 1 = little-endian, 0 = big-endian |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_waddr | output | 30 | Word address to memory |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |
| wb_valid | output | 1 | Write-back strobe |
| wb_tag | output | TAG_W | Write-back destination tag |
| wb_data | output | 32 | Write-back data |
| wb_mmio | output | 1 | Load hit the I/O window |
| wb_cache_upd | output | 1 | Cache-status update due |

## Verification
The bench targets the wraparound of a negative scaled index. A design that dropped the carry or forgot the scaling would read the wrong word. It also puts loads with alternating byte-order modes back to back, which catches a design that samples the mode bit late and swaps the wrong load. A false guard must leave both the memory strobe and all write-back outputs silent; a leaky guard would show up as a spurious read or strobe. The I/O window is loaded in big-endian mode and must come back in little-endian order. A reset that lands with a load in flight must not let that load reach write-back.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LANE_W = $clog2(WORD_BYTES);
  typedef logic [LANE_W-1:0] lane_sel_t;
  // XOR mask applied to the reversed lane index
  localparam lane_sel_t SEL_LITTLE = lane_sel_t'(WORD_BYTES - 1);
  localparam lane_sel_t SEL_BIG = '0;
endpackage

// File: rtl/ldx_agen.sv
module ldx_agen #(
  parameter int unsigned AW = 32,
  parameter int unsigned SCALE_SH = 2
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] scaled;
  always_comb begin
    scaled = index << SCALE_SH;
    ea = base + scaled;
  end
endmodule

// File: rtl/ldx_region_dec.sv
module ldx_region_dec #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] IO_LO = '0,
  parameter logic [AW-1:0] IO_HI = '0,
  parameter logic [AW-1:0] CC_LO = '0,
  parameter logic [AW-1:0] CC_HI = '0
) (
  input  logic [AW-1:0] addr,
  output logic          io_hit,
  output logic          cc_hit
);
  logic in_io, in_cc;
  always_comb begin
    in_io = (addr >= IO_LO) && (addr <= IO_HI);
    in_cc = (addr >= CC_LO) && (addr <= CC_HI);
    io_hit = in_io;
    cc_hit = in_cc && !in_io;
  end
endmodule

// File: rtl/ldx_lane_steer.sv
module ldx_lane_steer
  import ldx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] din,
  input  lane_sel_t     sel,
  output logic [DW-1:0] dout
);
  localparam int unsigned NB = DW / 8;
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int unsigned REV = NB - 1 - k;
    lane_sel_t src;
    assign src = lane_sel_t'(REV) ^ sel;
    assign dout[8*k +: 8] = din[8*src +: 8];
  end
endmodule

// File: rtl/ldx_word_unit.sv
module ldx_word_unit
  import ldx_pkg::*;
#(
  parameter int unsigned TAG_W = 7,
  parameter logic [31:0] MMIO_BASE = 32'hEFE0_0000,
  parameter logic [31:0] MMIO_LIMIT = 32'hEFFF_FFFF,
  parameter logic [31:0] CACHE_BASE = 32'h0000_0000,
  parameter logic [31:0] CACHE_LIMIT = 32'h7FFF_FFFF,
  parameter bit MMIO_LITTLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [31:0]      iss_base,
  input  logic [31:0]      iss_index,
  input  logic             iss_guard,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             iss_little,
  output logic             mem_rd_en,
  output logic [29:0]      mem_waddr,
  input  logic [31:0]      mem_rdata,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic [31:0]      wb_data,
  output logic             wb_mmio,
  output logic             wb_cache_upd
);
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned WA_LSB = $clog2(WORD_BYTES);
  localparam lane_sel_t IO_SEL = MMIO_LITTLE ? SEL_LITTLE : SEL_BIG;

  logic [AW-1:0] ea;
  logic io_hit, cc_hit, fire;
  lane_sel_t sel_now;

  ldx_agen #(.AW(AW), .SCALE_SH(WA_LSB)) u_agen (
    .base(iss_base), .index(iss_index), .ea(ea)
  );

  ldx_region_dec #(
    .AW(AW), .IO_LO(MMIO_BASE), .IO_HI(MMIO_LIMIT),
    .CC_LO(CACHE_BASE), .CC_HI(CACHE_LIMIT)
  ) u_dec (
    .addr(ea), .io_hit(io_hit), .cc_hit(cc_hit)
  );

  assign iss_ready = !rst;
  assign fire = iss_valid && iss_ready;
  assign mem_rd_en = fire && iss_guard;
  assign mem_waddr = ea[AW-1:WA_LSB];
  assign sel_now = io_hit ? IO_SEL : (iss_little ? SEL_LITTLE : SEL_BIG);

  // stage 1: request in flight to memory
  logic             s1_v, s1_g, s1_io, s1_cc;
  logic [TAG_W-1:0] s1_tag;
  lane_sel_t        s1_sel;
  // stage 2: steered data
  logic             s2_v, s2_g, s2_io, s2_cc;
  logic [TAG_W-1:0] s2_tag;
  logic [DW-1:0]    s2_data;
  logic [DW-1:0]    steered;
  // stage 3: write-back
  logic             s3_v, s3_g, s3_io, s3_cc;

  ldx_lane_steer #(.DW(DW)) u_steer (
    .din(mem_rdata), .sel(s1_sel), .dout(steered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s1_v <= fire;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_g   <= iss_guard;
    s1_tag <= iss_tag;
    s1_sel <= sel_now;
    s1_io  <= io_hit;
    s1_cc  <= cc_hit;

    s2_g    <= s1_g;
    s2_tag  <= s1_tag;
    s2_io   <= s1_io;
    s2_cc   <= s1_cc;
    s2_data <= steered;

    s3_g    <= s2_g;
    s3_io   <= s2_io;
    s3_cc   <= s2_cc;
    wb_tag  <= s2_tag;
    wb_data <= s2_data;
  end

  assign wb_valid     = s3_v && s3_g;
  assign wb_mmio      = wb_valid && s3_io;
  assign wb_cache_upd = wb_valid && s3_cc;
endmodule

// File: rtl/ldx_word_unit_chk.sv
module ldx_word_unit_chk #(
  parameter int unsigned TAG_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_guard,
  input logic [TAG_W-1:0] iss_tag,
  input logic             mem_rd_en,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic             wb_mmio,
  input logic             wb_cache_upd
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R4: every guarded issue reaches write-back three cycles later with its tag
  a_r4_wb_after_issue: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(iss_valid && iss_ready && iss_guard, 3))
      |-> (wb_valid && wb_tag == $past(iss_tag, 3)));

  // R5: a write-back needs a guarded issue three cycles earlier
  a_r5_no_wb_without_guard: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && wb_valid) |-> $past(iss_valid && iss_guard, 3));

  // R5: the memory strobe is never raised for a false guard
  a_r5_no_read_on_false_guard: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_guard) |-> !mem_rd_en);

  // R8: side-effect flags are exclusive and ride only on a write-back
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    (wb_mmio || wb_cache_upd) |-> (wb_valid && !(wb_mmio && wb_cache_upd)));

  // R10: nothing left over in the cycle after reset
  a_r10_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wb_valid);

  // R11: issue side open outside reset
  a_r11_ready_outside_reset: assert property (@(posedge clk) disable iff (rst)
    iss_ready);
endmodule

bind ldx_word_unit ldx_word_unit_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_guard(iss_guard), .iss_tag(iss_tag), .mem_rd_en(mem_rd_en),
  .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_mmio(wb_mmio),
  .wb_cache_upd(wb_cache_upd)
);

// File: tb/tb_ldx_word_unit.sv
module tb_ldx_word_unit;
  localparam int TW = 7;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0, iss_guard = 1'b0, iss_little = 1'b0;
  logic [31:0] iss_base = '0, iss_index = '0;
  logic [TW-1:0] iss_tag = '0;
  logic iss_ready, mem_rd_en, wb_valid, wb_mmio, wb_cache_upd;
  logic [29:0] mem_waddr;
  logic [31:0] mem_rdata = '0, wb_data;
  logic [TW-1:0] wb_tag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ldx_word_unit #(.TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_base(iss_base), .iss_index(iss_index), .iss_guard(iss_guard),
    .iss_tag(iss_tag), .iss_little(iss_little), .mem_rd_en(mem_rd_en),
    .mem_waddr(mem_waddr), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .wb_mmio(wb_mmio),
    .wb_cache_upd(wb_cache_upd)
  );

  function automatic logic [31:0] mem_word(logic [29:0] w);
    if (w == 30'h340) return 32'h1122_3384;
    if (w == 30'h341) return 32'h4455_6648;
    return {w[7:0] ^ 8'h3C, w[15:8], w[7:0] ^ 8'hC3, w[7:0]};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_waddr);

  function automatic logic [31:0] order(logic [31:0] w, bit little);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = little ? w[8*k +: 8] : w[8*(3-k) +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] b, logic [31:0] i, logic g, logic le, logic [TW-1:0] t);
    iss_valid = 1'b1; iss_base = b; iss_index = i; iss_guard = g;
    iss_little = le; iss_tag = t;
  endtask

  // one load alone in the pipe, checked at issue and at write-back
  task automatic single(string req, logic [31:0] b, logic [31:0] i, logic g, logic le,
                        logic [TW-1:0] t, bit dchk, logic [31:0] exp_d, bit exp_io, bit exp_cc);
    logic [31:0] ea;
    ea = b + (i << 2);
    @(negedge clk); drive(b, i, g, le, t); #1;
    chk({req, " rd_en at issue"}, {31'd0, mem_rd_en}, {31'd0, g});
    if (g) chk({req, " R1 word address"}, {2'b0, mem_waddr}, {2'b0, ea[31:2]});
    @(negedge clk); iss_valid = 1'b0; iss_little = ~le;
    chk({req, " R4 no early wb"}, {31'd0, wb_valid}, 32'd0);
    @(negedge clk);
    chk({req, " R4 no early wb"}, {31'd0, wb_valid}, 32'd0);
    @(negedge clk);
    chk({req, " wb_valid"}, {31'd0, wb_valid}, {31'd0, g});
    chk({req, " wb_mmio"}, {31'd0, wb_mmio}, {31'd0, g & exp_io});
    chk({req, " wb_cache_upd"}, {31'd0, wb_cache_upd}, {31'd0, g & exp_cc});
    if (g) chk({req, " tag"}, {25'd0, wb_tag}, {25'd0, t});
    if (g && dchk) chk({req, " data"}, wb_data, exp_d);
    @(negedge clk);
    chk({req, " R4 single wb"}, {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 ready low in reset", {31'd0, iss_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready after reset", {31'd0, iss_ready}, 32'd1);
    chk("R10 no wb after reset", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_examples();
    single("R2 big-endian", 32'hCFC, 32'd1, 1'b1, 1'b0, 7'd5, 1, 32'h8433_2211, 0, 1);
    single("R3 little-endian", 32'hCFC, 32'd1, 1'b1, 1'b1, 7'd6, 1, 32'h1122_3384, 0, 1);
    single("R1 negative index", 32'hD0C, 32'hFFFF_FFFE, 1'b1, 1'b0, 7'd7, 1, 32'h4866_5544, 0, 1);
    single("R5 false guard", 32'hD0C, 32'hFFFF_FFFE, 1'b0, 1'b0, 7'd8, 0, 32'd0, 0, 1);
    single("R6 misaligned", 32'hD01, 32'd1, 1'b1, 1'b0, 7'd9, 0, 32'd0, 0, 1);
  endtask

  task automatic t_regions();
    logic [31:0] w;
    w = mem_word(30'h3BF8_0004);
    single("R7 io big mode", 32'hEFE0_0000, 32'd4, 1'b1, 1'b0, 7'd10, 1, order(w, 1), 1, 0);
    single("R7 io little mode", 32'hEFE0_0000, 32'd4, 1'b1, 1'b1, 7'd11, 1, order(w, 1), 1, 0);
    w = mem_word(30'h2400_0001);
    single("R8 uncached", 32'h9000_0000, 32'd1, 1'b1, 1'b0, 7'd12, 1, order(w, 0), 0, 0);
  endtask

  // back-to-back issues with the mode bit flipping each cycle
  task automatic t_stream();
    logic [31:0] b [4] = '{32'hCFC, 32'hCFC, 32'hD0C, 32'hD00};
    logic [31:0] ix [4] = '{32'd1, 32'd1, 32'hFFFF_FFFE, 32'd1};
    logic g [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    logic le [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    logic [31:0] ed [4] = '{32'h8433_2211, 32'h1122_3384, 32'd0, 32'h4455_6648};
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk("R4 R9 stream valid", {31'd0, wb_valid}, {31'd0, g[k-3]});
        if (g[k-3]) begin
          chk("R4 stream tag", {25'd0, wb_tag}, 32'(20 + k - 3));
          chk("R9 stream data", wb_data, ed[k-3]);
        end
      end
      if (k < 4) drive(b[k], ix[k], g[k], le[k], 7'(20 + k));
      else begin iss_valid = 1'b0; iss_little = ~iss_little; end
    end
  endtask

  task automatic t_reset_flight();
    @(negedge clk); drive(32'hCFC, 32'd1, 1'b1, 1'b0, 7'd30);
    @(negedge clk); iss_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 flushed load", {31'd0, wb_valid}, 32'd0);
    end
  endtask

  initial begin
    t_reset();
    t_examples();
    t_regions();
    t_stream();
    t_reset_flight();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule